// File: doc/BRIEF.md
# LIN Operating State Sequencer

This block keeps the operating state of a UART-based LIN node and decides when hardware may move that state on its own. Software writes a configuration word that sets the state, the node role (master or slave) and the break-length code. In slave role, hardware walks the node from waiting for a break, through baud measurement, into the active state, driven by strobes from a break detector and an autobaud unit. In master role, the node goes straight from sleep to active and stays there until software puts it back to sleep.

In master role the block also shapes the break field. A start strobe pulls the transmit drive low for 13 to 16 bit-time ticks, counted from the baud generator's tick. A done pulse marks the end of the break. Each state change raises a single-cycle pulse that can feed an interrupt.

Top module: `lin_state_ctrl`

## Requirements
- R1: After reset the state output is Sleep (00), `txd_brk` is high, and `brk_done` and `state_chg` are low.
- R2: A write (`cfg_wr` high) loads `cfg_state` into the state on the next clock, taking precedence over any hardware transition in the same cycle. The codes are Sleep=00, WaitBreak=01, Autobaud=10 and Active=11.
- R3: In slave role, WaitBreak moves to Autobaud on the clock after a `brk_det` strobe, but only while `rxd` is low. A strobe while `rxd` is high is ignored.
- R4: In slave role, Autobaud moves to Active on the clock after an `ab_done` strobe. `ab_done` has no effect in any other state.
- R5: Hardware never enters Sleep and never leaves Active. In master role, `brk_det` and `ab_done` never change the state.
- R6: A break holds `txd_brk` low from the clock after the start strobe until the clock of the N-th `bit_tick`, where N is 13, 14, 15 or 16 for `cfg_brk_len` codes 00, 01, 10 and 11. Clock cycles without a tick do not count.
- R7: `brk_start` begins a break only in master role, in state Active, and with no break already running. Otherwise it is ignored.
- R8: When a break completes, `brk_done` is high for exactly one cycle, in the same cycle that `txd_brk` returns high.
- R9: A write that moves the state out of Active during a break ends the break: `txd_brk` is high on the next clock and no `brk_done` pulse follows.
- R10: `state_chg` is high for exactly one cycle, in the first cycle that shows a new state value. A write of the current state raises no pulse.
- R11: The break length is taken at the start strobe. A write to `cfg_brk_len` during a break does not change the running break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_state | input | 2 | State value to write |
| cfg_master | input | 1 | Role to write: 1 master, 0 slave |
| cfg_brk_len | input | 2 | Break-length code to write |
| bit_tick | input | 1 | One pulse per bit time from the baud generator |
| rxd | input | 1 | Receive line level |
| brk_det | input | 1 | Break-detected strobe |
| ab_done | input | 1 | Autobaud-complete strobe |
| brk_start | input | 1 | Master break start strobe |
| state | output | 2 | Current state |
| txd_brk | output | 1 | Transmit drive, low during a break |
| brk_done | output | 1 | Break-complete pulse |
| state_chg | output | 1 | State-change pulse |

## Verification
The bench writes a new state in the same cycle as a break-detected strobe. A design that let hardware win would show Autobaud instead of the written value. It sends strobes in the wrong state or role, and a break-detected strobe while the line is high. A design that ignored these gates would advance the state or start a break where none belongs. Breaks of different lengths run with gaps between ticks, with a length rewrite and a second start strobe in the middle. An off-by-one counter, a counter that counts clocks instead of ticks, or a length that is not captured at the start all show up as a wrong release cycle. An abort to Sleep in mid-break catches a design that keeps the line low or still emits a done pulse.

// File: rtl/lin_state_ctrl.sv
`timescale 1ns/1ps
module lin_state_ctrl #(
  parameter int BRK_BASE = 13,
  parameter int LEN_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_state,
  input  logic             cfg_master,
  input  logic [LEN_W-1:0] cfg_brk_len,
  input  logic             bit_tick,
  input  logic             rxd,
  input  logic             brk_det,
  input  logic             ab_done,
  input  logic             brk_start,
  output logic [1:0]       state,
  output logic             txd_brk,
  output logic             brk_done,
  output logic             state_chg
);
  localparam int CNT_W = $clog2(BRK_BASE + (1 << LEN_W));
  localparam logic [1:0] ST_SLEEP = 2'b00;
  localparam logic [1:0] ST_WAIT  = 2'b01;
  localparam logic [1:0] ST_AUTO  = 2'b10;
  localparam logic [1:0] ST_ACT   = 2'b11;

  logic [1:0]       state_q, state_d;
  logic             master_q;
  logic [LEN_W-1:0] len_q;
  logic             busy_q, done_q, chg_q;
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             brk_go, brk_end, brk_abort;

  always_comb begin
    state_d = state_q;
    if (cfg_wr)
      state_d = cfg_state;
    else if (!master_q) begin
      if (state_q == ST_WAIT && brk_det && !rxd)
        state_d = ST_AUTO;
      else if (state_q == ST_AUTO && ab_done)
        state_d = ST_ACT;
    end
  end

  assign brk_go    = brk_start && !busy_q && master_q && state_q == ST_ACT && state_d == ST_ACT;
  assign brk_abort = busy_q && state_d != ST_ACT;
  assign brk_end   = busy_q && bit_tick && cnt_q == lim_q && !brk_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SLEEP;
      master_q <= 1'b0;
      len_q    <= '0;
      chg_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      chg_q   <= state_d != state_q;
      if (cfg_wr) begin
        master_q <= cfg_master;
        len_q    <= cfg_brk_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else begin
      done_q <= brk_end;
      if (brk_go) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        lim_q  <= CNT_W'(BRK_BASE - 1) + CNT_W'(len_q);
      end else if (brk_abort || brk_end) begin
        busy_q <= 1'b0;
      end else if (busy_q && bit_tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state     = state_q;
  assign txd_brk   = !busy_q;
  assign brk_done  = done_q;
  assign state_chg = chg_q;
endmodule

// File: rtl/lin_state_ctrl_chk.sv
`timescale 1ns/1ps
module lin_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [1:0] cfg_state,
  input logic       rxd,
  input logic       brk_det,
  input logic       ab_done,
  input logic       master_q,
  input logic [1:0] state,
  input logic       txd_brk,
  input logic       brk_done,
  input logic       state_chg
);
  a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> state == $past(cfg_state));
  a_r3_wait_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !master_q && state == 2'b01 && brk_det && !rxd) |=> state == 2'b10);
  a_r4_auto_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !master_q && state == 2'b10 && ab_done) |=> state == 2'b11);
  a_r5_no_hw_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && state != 2'b00) |=> state != 2'b00);
  a_r5_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && state == 2'b11) |=> state == 2'b11);
  a_r7_low_in_act: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_brk |-> state == 2'b11);
  a_r8_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |-> (txd_brk && !$past(txd_brk)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |=> !brk_done);
  a_r10_chg_real: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg |-> state != $past(state));
  a_r10_chg_seen: assert property (@(posedge clk) disable iff (!rst_n)
    state != $past(state) |-> state_chg);
endmodule

bind lin_state_ctrl lin_state_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_state(cfg_state),
  .rxd(rxd), .brk_det(brk_det), .ab_done(ab_done), .master_q(master_q),
  .state(state), .txd_brk(txd_brk), .brk_done(brk_done), .state_chg(state_chg)
);

// File: tb/lin_state_ctrl_tb.sv
`timescale 1ns/1ps
module lin_state_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 0, cm = 0, tick = 0, rxd = 1, bd = 0, ad = 0, bs = 0;
  logic [1:0] cst = 0, clen = 0;
  logic [1:0] state;
  logic txd_brk, brk_done, state_chg;

  always #2.5 clk = ~clk;

  lin_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr), .cfg_state(cst), .cfg_master(cm),
    .cfg_brk_len(clen), .bit_tick(tick), .rxd(rxd), .brk_det(bd), .ab_done(ad),
    .brk_start(bs), .state(state), .txd_brk(txd_brk), .brk_done(brk_done),
    .state_chg(state_chg)
  );

  typedef struct {
    int         req;
    logic [1:0] st;
    logic       tx;
    logic       dn;
    logic       ch;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit fin = 0;

  task automatic cyc(input int req, input logic [1:0] st, input logic tx,
                     input logic dn, input logic ch);
    exp_t e;
    e.req = req; e.st = st; e.tx = tx; e.dn = dn; e.ch = ch;
    q.push_back(e);
    @(negedge clk);
    wr = 0; bd = 0; ad = 0; bs = 0; tick = 0;
  endtask

  task automatic wcfg(input logic [1:0] s, input logic m, input logic [1:0] l);
    wr = 1; cst = s; cm = m; clen = l;
  endtask

  task automatic brk(input int req, input int n, input int gap);
    bs = 1;
    cyc(req, 2'b11, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      repeat (gap) cyc(req, 2'b11, 0, 0, 0);
      tick = 1;
      if (i < n - 1) cyc(req, 2'b11, 0, 0, 0);
      else cyc(req, 2'b11, 1, 1, 0);
    end
    cyc(req, 2'b11, 1, 0, 0);
  endtask

  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_run++;
        if (state !== e.st || txd_brk !== e.tx || brk_done !== e.dn || state_chg !== e.ch) begin
          n_fail++;
          $display("FAIL R%0d: state=%b tx=%b done=%b chg=%b expected state=%b tx=%b done=%b chg=%b",
                   e.req, state, txd_brk, brk_done, state_chg, e.st, e.tx, e.dn, e.ch);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(1, 2'b00, 1, 0, 0);                          // R1 reset state
    cyc(1, 2'b00, 1, 0, 0);

    wcfg(2'b01, 0, 0); cyc(2, 2'b01, 1, 0, 1);       // R2 write to WaitBreak, R10 pulse
    cyc(10, 2'b01, 1, 0, 0);                         // R10 pulse is single
    bd = 1; rxd = 1; cyc(3, 2'b01, 1, 0, 0);         // R3 strobe with line high ignored
    ad = 1; cyc(4, 2'b01, 1, 0, 0);                  // R4 ab_done in WaitBreak ignored
    bd = 1; rxd = 0; cyc(3, 2'b10, 1, 0, 1);         // R3 advance to Autobaud
    rxd = 1;
    bs = 1; cyc(7, 2'b10, 1, 0, 0);                  // R7 start outside Active ignored
    ad = 1; cyc(4, 2'b11, 1, 0, 1);                  // R4 advance to Active
    bs = 1; cyc(7, 2'b11, 1, 0, 0);                  // R7 slave role cannot start a break
    repeat (3) cyc(5, 2'b11, 1, 0, 0);               // R5 Active held
    wcfg(2'b00, 0, 0); cyc(5, 2'b00, 1, 0, 1);       // R5 software returns to Sleep
    repeat (2) cyc(5, 2'b00, 1, 0, 0);

    wcfg(2'b01, 0, 0); cyc(2, 2'b01, 1, 0, 1);
    wcfg(2'b11, 0, 0); bd = 1; rxd = 0;
    cyc(2, 2'b11, 1, 0, 1);                          // R2 write beats hardware advance
    rxd = 1;
    wcfg(2'b11, 0, 0); cyc(10, 2'b11, 1, 0, 0);      // R10 same-value write, no pulse
    wcfg(2'b00, 0, 0); cyc(10, 2'b00, 1, 0, 1);
    wcfg(2'b00, 0, 0); cyc(10, 2'b00, 1, 0, 0);      // R10

    wcfg(2'b01, 1, 0); cyc(2, 2'b01, 1, 0, 1);
    bd = 1; rxd = 0; cyc(5, 2'b01, 1, 0, 0);         // R5 master ignores brk_det
    rxd = 1;
    wcfg(2'b10, 1, 0); cyc(2, 2'b10, 1, 0, 1);
    ad = 1; cyc(5, 2'b10, 1, 0, 0);                  // R5 master ignores ab_done
    wcfg(2'b11, 1, 0); cyc(2, 2'b11, 1, 0, 1);

    brk(6, 13, 0);                                   // R6 code 00, R8 done pulse
    wcfg(2'b11, 1, 1); cyc(6, 2'b11, 1, 0, 0);
    brk(6, 14, 2);                                   // R6 code 01, ticks with gaps
    wcfg(2'b11, 1, 2); cyc(6, 2'b11, 1, 0, 0);
    brk(6, 15, 1);                                   // R6 code 10

    wcfg(2'b11, 1, 3); cyc(11, 2'b11, 1, 0, 0);
    bs = 1; cyc(11, 2'b11, 0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      tick = 1;
      if (i == 4) begin wcfg(2'b11, 1, 0); bs = 1; end  // R11 length rewrite, R7 restart ignored
      if (i < 15) cyc(11, 2'b11, 0, 0, 0);
      else cyc(8, 2'b11, 1, 1, 0);                   // R8 done with release
    end
    cyc(8, 2'b11, 1, 0, 0);                          // R8 single pulse

    wcfg(2'b11, 1, 2); cyc(9, 2'b11, 1, 0, 0);
    bs = 1; cyc(9, 2'b11, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin tick = 1; cyc(9, 2'b11, 0, 0, 0); end
    wcfg(2'b00, 1, 2); tick = 1; cyc(9, 2'b00, 1, 0, 1);  // R9 abort releases line
    repeat (14) begin tick = 1; cyc(9, 2'b00, 1, 0, 0); end  // R9 no done pulse later

    wcfg(2'b11, 1, 0); cyc(2, 2'b11, 1, 0, 1);
    brk(6, 13, 0);                                   // R6 break works after abort

    cyc(1, 2'b11, 1, 0, 0);
    @(negedge clk);
    fin = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule